// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves a virtual address into a leaf page table entry when a translation lookaside buffer misses. A walk starts from a context number and a context table base register. The walker first reads the context slot, then follows table pointer descriptors down through as many as three table levels. Memory access is a single word-wide read port and a single write port, each with a valid/ready handshake. Only one walk is in flight at a time.

A leaf may appear at any level, so a large mapping ends the walk early. The level at which the leaf was found gives the mapping size:
- level 1 maps 16 MB,
- level 2 maps 256 KB,
- level 3 maps 4 KB,
- level 0, a leaf in the context slot itself, covers the whole space.

A bad descriptor ends the walk with a fault code, the level reached and the failing virtual address. On a successful walk the walker sets the referenced bit, and the modified bit for a write access, by writing the entry back before it reports completion.

Top module: `pt_walker`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `rd_valid` and `wr_valid` are all low.
- R2: The first read of a walk goes to the byte address `(ctx_table_ptr & ~0xF) << 4` plus four times `ctx_num`. The address is 36 bits wide.
- R3: A descriptor whose bits 1:0 equal 1 is a table pointer. The next table base is `(desc & ~0xF) << 4`. The next read is that base plus four times the level index. The index is vaddr[31:24] at level 1, vaddr[23:18] at level 2 and vaddr[17:12] at level 3.
- R4: A descriptor whose bits 1:0 equal 2 is a leaf. The walk ends without a fault at the level where the leaf was read (0 for the context slot, then 1, 2 or 3), after exactly that level plus one reads. A successful walk reports fault code 0.
- R5: The walk ends with `res_fault` high and with `res_level` and `res_fault_vaddr` equal to the level reached and the request address. The fault code is:
  - 1 for an invalid descriptor (type 0),
  - 2 for the reserved type 3,
  - 3 for a table pointer read at level 3.

  A faulting walk performs no write.
- R6: When the leaf's referenced bit (bit 5) is clear, or the access is a write and its modified bit (bit 6) is clear, the walker writes the entry back to the address it was read from. The written value has bit 5 set, and bit 6 set for a write access. `res_entry` equals the written value.
- R7: When neither condition of R6 holds, no write occurs and `res_entry` equals the leaf exactly as read.
- R8: While `busy` is high a request is ignored. It does not change the read addresses of the walk in progress and does not start a second walk.
- R9: `rd_valid` and `rd_addr` stay stable until `rd_ready` is seen. At most one read is outstanding, and reads and writes never overlap.
- R10: `done` is high for exactly one cycle per walk, and a walk issues at most four reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a walk (taken only when not busy) |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a store |
| busy | output | 1 | A walk is in progress |
| ctx_table_ptr | input | 32 | Context table base, physical address shifted right by 4 |
| ctx_num | input | 8 | Current context number |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | 36 | Read byte address |
| rd_rvalid | input | 1 | Read data valid |
| rd_rdata | input | 32 | Read data word |
| wr_valid | output | 1 | Write-back request valid |
| wr_ready | input | 1 | Write-back accepted |
| wr_addr | output | 36 | Write-back byte address |
| wr_data | output | 32 | Updated entry to write |
| done | output | 1 | Walk finished, results valid this cycle |
| res_entry | output | 32 | Leaf entry (updated) or faulting descriptor |
| res_level | output | 2 | Level where the walk ended |
| res_fault | output | 1 | Walk ended in a fault |
| res_fault_code | output | 2 | 0 none, 1 invalid, 2 reserved, 3 too deep |
| res_fault_vaddr | output | 32 | Virtual address of the walk |

## Verification
The checker watches the protocol properties on every cycle:
- read and write requests hold stable until accepted,
- reads and writes never overlap,
- `done` is a one-cycle pulse and only appears while busy,
- every write-back carries the referenced bit,
- the fault code agrees with the fault flag,
- no walk exceeds four reads.

Some behaviours can only be shown by the bench's scenarios, which build page tables in a memory model and compare results against values computed from the requirements. These are:
- the exact address arithmetic at each level,
- the level at which each leaf terminates,
- the choice between write-back and no write-back for each combination of referenced bit, modified bit and access type,
- each fault code,
- the refusal of a request that arrives mid-walk.

// File: rtl/wlk_pkg.sv
// Package: shared types and constants for the page table walker.
// Assumes 32-bit descriptors with the type code in bits 1:0.
package wlk_pkg;

    localparam int DESC_W    = 32;
    localparam int PTR_SHIFT = 4;
    localparam int BIT_REF   = 5;
    localparam int BIT_MOD   = 6;

    localparam logic [DESC_W-1:0] PTR_MASK = ~32'h0000_000F;

    localparam logic [1:0] TY_INVALID = 2'd0;
    localparam logic [1:0] TY_TABLE   = 2'd1;
    localparam logic [1:0] TY_LEAF    = 2'd2;
    localparam logic [1:0] TY_RSVD    = 2'd3;

    localparam logic [1:0] FC_NONE     = 2'd0;
    localparam logic [1:0] FC_INVALID  = 2'd1;
    localparam logic [1:0] FC_RESERVED = 2'd2;
    localparam logic [1:0] FC_DEPTH    = 2'd3;

    localparam logic [1:0] LAST_LVL = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        DK_DESCEND,
        DK_LEAF,
        DK_FAULT
    } desc_kind_e;

endpackage

// File: rtl/pt_walk_addr.sv
// Address generator: forms the byte address of the descriptor to read at
// the current level. Level 0 indexes the context table by context number;
// levels 1..3 index the current table by a slice of the virtual page number.
// Assumes the base is already a byte address and entries are 4 bytes.
module pt_walk_addr #(
    parameter int PA_W    = 36,
    parameter int CTX_W   = 8,
    parameter int L1_BITS = 8,
    parameter int L2_BITS = 6,
    parameter int L3_BITS = 6,
    localparam int VPN_W  = L1_BITS + L2_BITS + L3_BITS
) (
    input  logic [1:0]       lvl,
    input  logic [PA_W-1:0]  base,
    input  logic [VPN_W-1:0] vpn,
    input  logic [CTX_W-1:0] ctx,
    output logic [PA_W-1:0]  addr
);
    localparam int L2_LSB = L3_BITS;
    localparam int L1_LSB = L3_BITS + L2_BITS;

    logic [PA_W-1:0] idx;

    // Select the table index for the current level and scale it to bytes.
    always_comb begin
        case (lvl)
            2'd0:    idx = PA_W'(ctx);
            2'd1:    idx = PA_W'(vpn[L1_LSB +: L1_BITS]);
            2'd2:    idx = PA_W'(vpn[L2_LSB +: L2_BITS]);
            default: idx = PA_W'(vpn[0 +: L3_BITS]);
        endcase
        addr = base + (idx << 2);
    end
endmodule

// File: rtl/pt_walk_decode.sv
// Descriptor decoder: classifies a fetched word as descend, leaf or fault,
// gives the fault code, the next table base and the updated leaf value with
// referenced/modified set as needed. Purely combinational.
module pt_walk_decode
    import wlk_pkg::*;
#(
    parameter int PA_W = 36
) (
    input  logic [DESC_W-1:0] desc,
    input  logic [1:0]        lvl,
    input  logic              is_write,
    output desc_kind_e        kind,
    output logic [1:0]        fcode,
    output logic              need_wb,
    output logic [DESC_W-1:0] upd,
    output logic [PA_W-1:0]   next_base
);
    // Type code decides whether the walk continues, terminates or faults.
    always_comb begin
        kind  = DK_FAULT;
        fcode = FC_INVALID;
        case (desc[1:0])
            TY_TABLE: begin
                if (lvl == LAST_LVL) begin
                    fcode = FC_DEPTH;
                end else begin
                    kind  = DK_DESCEND;
                    fcode = FC_NONE;
                end
            end
            TY_LEAF: begin
                kind  = DK_LEAF;
                fcode = FC_NONE;
            end
            TY_RSVD:  fcode = FC_RESERVED;
            default:  fcode = FC_INVALID;
        endcase
    end

    // Leaf update and pointer expansion.
    always_comb begin
        upd = desc;
        upd[BIT_REF] = 1'b1;
        if (is_write) upd[BIT_MOD] = 1'b1;
        need_wb   = (kind == DK_LEAF) && (upd != desc);
        next_base = PA_W'(desc & PTR_MASK) << PTR_SHIFT;
    end
endmodule

// File: rtl/pt_walker.sv
// Page table walker top: accepts one request at a time, reads the context
// slot and up to three table levels over a valid/ready read port, writes
// back a leaf whose referenced/modified bits need setting, then pulses done
// with the result. Assumes the read data returns one or more cycles after
// the read request handshake and that tables are 256-byte aligned.
module pt_walker
    import wlk_pkg::*;
#(
    parameter int CTX_W      = 8,
    parameter int PA_W       = 36,
    parameter int L1_BITS    = 8,
    parameter int L2_BITS    = 6,
    parameter int L3_BITS    = 6,
    parameter int PAGE_SHIFT = 12,
    localparam int VA_W      = PAGE_SHIFT + L3_BITS + L2_BITS + L1_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    output logic              busy,
    input  logic [DESC_W-1:0] ctx_table_ptr,
    input  logic [CTX_W-1:0]  ctx_num,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [PA_W-1:0]   rd_addr,
    input  logic              rd_rvalid,
    input  logic [DESC_W-1:0] rd_rdata,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [PA_W-1:0]   wr_addr,
    output logic [DESC_W-1:0] wr_data,
    output logic              done,
    output logic [DESC_W-1:0] res_entry,
    output logic [1:0]        res_level,
    output logic              res_fault,
    output logic [1:0]        res_fault_code,
    output logic [VA_W-1:0]   res_fault_vaddr
);
    walk_state_e       state;
    logic [1:0]        lvl;
    logic [PA_W-1:0]   base_q;
    logic [PA_W-1:0]   addr_q;
    logic [VA_W-1:0]   vaddr_q;
    logic              write_q;
    logic [CTX_W-1:0]  ctx_q;
    logic [DESC_W-1:0] entry_q;
    logic [1:0]        level_q;
    logic              fault_q;
    logic [1:0]        code_q;

    desc_kind_e        kind;
    logic [1:0]        fcode;
    logic              need_wb;
    logic [DESC_W-1:0] upd;
    logic [PA_W-1:0]   next_base;

    pt_walk_addr #(
        .PA_W    (PA_W),
        .CTX_W   (CTX_W),
        .L1_BITS (L1_BITS),
        .L2_BITS (L2_BITS),
        .L3_BITS (L3_BITS)
    ) u_addr (
        .lvl  (lvl),
        .base (base_q),
        .vpn  (vaddr_q[VA_W-1:PAGE_SHIFT]),
        .ctx  (ctx_q),
        .addr (rd_addr)
    );

    pt_walk_decode #(
        .PA_W (PA_W)
    ) u_dec (
        .desc      (rd_rdata),
        .lvl       (lvl),
        .is_write  (write_q),
        .kind      (kind),
        .fcode     (fcode),
        .need_wb   (need_wb),
        .upd       (upd),
        .next_base (next_base)
    );

    // Walk sequencer: request capture, per-level read, write-back, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            lvl     <= 2'd0;
            base_q  <= '0;
            addr_q  <= '0;
            vaddr_q <= '0;
            write_q <= 1'b0;
            ctx_q   <= '0;
            entry_q <= '0;
            level_q <= 2'd0;
            fault_q <= 1'b0;
            code_q  <= FC_NONE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        vaddr_q <= req_vaddr;
                        write_q <= req_write;
                        ctx_q   <= ctx_num;
                        base_q  <= PA_W'(ctx_table_ptr & PTR_MASK) << PTR_SHIFT;
                        lvl     <= 2'd0;
                        state   <= ST_RD_REQ;
                    end
                end
                ST_RD_REQ: begin
                    if (rd_ready) begin
                        addr_q <= rd_addr;
                        state  <= ST_RD_WAIT;
                    end
                end
                ST_RD_WAIT: begin
                    if (rd_rvalid) begin
                        level_q <= lvl;
                        code_q  <= fcode;
                        case (kind)
                            DK_DESCEND: begin
                                base_q <= next_base;
                                lvl    <= lvl + 2'd1;
                                state  <= ST_RD_REQ;
                            end
                            DK_LEAF: begin
                                entry_q <= upd;
                                fault_q <= 1'b0;
                                state   <= need_wb ? ST_WR_REQ : ST_DONE;
                            end
                            default: begin
                                entry_q <= rd_rdata;
                                fault_q <= 1'b1;
                                state   <= ST_DONE;
                            end
                        endcase
                    end
                end
                ST_WR_REQ: begin
                    if (wr_ready) state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port drive from state and result registers.
    always_comb begin
        busy            = (state != ST_IDLE);
        rd_valid        = (state == ST_RD_REQ);
        wr_valid        = (state == ST_WR_REQ);
        wr_addr         = addr_q;
        wr_data         = entry_q;
        done            = (state == ST_DONE);
        res_entry       = entry_q;
        res_level       = level_q;
        res_fault       = fault_q;
        res_fault_code  = code_q;
        res_fault_vaddr = vaddr_q;
    end
endmodule

// File: rtl/pt_walker_chk.sv
// Checker: protocol and result-consistency properties for pt_walker,
// attached by bind. Counts read handshakes per walk to bound the depth.
module pt_walker_chk #(
    parameter int PA_W = 36
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            busy,
    input logic            rd_valid,
    input logic            rd_ready,
    input logic [PA_W-1:0] rd_addr,
    input logic            wr_valid,
    input logic            wr_ready,
    input logic [PA_W-1:0] wr_addr,
    input logic [31:0]     wr_data,
    input logic            done,
    input logic            res_fault,
    input logic [1:0]      res_fault_code
);
    logic [2:0] rd_cnt;

    // Read handshakes since the last accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   rd_cnt <= 3'd0;
        else if (req_valid && !busy)                  rd_cnt <= 3'd0;
        else if (rd_valid && rd_ready && rd_cnt != 3'd7) rd_cnt <= rd_cnt + 3'd1;
    end

    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

    p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && wr_valid));

    p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    p_wr_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_data[5]);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_rd_max_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_cnt < 3'd4);

    p_fault_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done && res_fault |-> res_fault_code != 2'd0);

    p_leaf_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done && !res_fault |-> res_fault_code == 2'd0);

    p_done_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_valid && !wr_valid && !done);
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .busy           (busy),
    .rd_valid       (rd_valid),
    .rd_ready       (rd_ready),
    .rd_addr        (rd_addr),
    .wr_valid       (wr_valid),
    .wr_ready       (wr_ready),
    .wr_addr        (wr_addr),
    .wr_data        (wr_data),
    .done           (done),
    .res_fault      (res_fault),
    .res_fault_code (res_fault_code)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
// Directed bench: builds page tables in a sparse memory model, runs one
// scenario per task and checks addresses, results and write-backs.
module pt_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        busy;
    logic [31:0] ctx_table_ptr = '0;
    logic [7:0]  ctx_num = '0;
    logic        rd_valid;
    logic        rd_ready = 1'b1;
    logic [35:0] rd_addr;
    logic        rd_rvalid = 1'b0;
    logic [31:0] rd_rdata = '0;
    logic        wr_valid;
    logic        wr_ready = 1'b1;
    logic [35:0] wr_addr;
    logic [31:0] wr_data;
    logic        done;
    logic [31:0] res_entry;
    logic [1:0]  res_level;
    logic        res_fault;
    logic [1:0]  res_fault_code;
    logic [31:0] res_fault_vaddr;

    pt_walker u_pt_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .busy(busy), .ctx_table_ptr(ctx_table_ptr),
        .ctx_num(ctx_num), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .rd_addr(rd_addr), .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .done(done), .res_entry(res_entry),
        .res_level(res_level), .res_fault(res_fault),
        .res_fault_code(res_fault_code), .res_fault_vaddr(res_fault_vaddr)
    );

    always #2 clk = ~clk;

    int n_checks = 0;
    int n_errs   = 0;
    bit finished = 1'b0;

    logic [31:0] mem [logic [35:0]];
    logic [35:0] rd_log [8];
    int          rd_n = 0;
    int          wr_n = 0;
    int          done_n = 0;
    logic [35:0] wr_last_addr = '0;
    logic [31:0] wr_last_data = '0;
    bit          stall = 1'b0;

    localparam logic [31:0] CTP = 32'h0001_0000;
    localparam logic [35:0] CT  = 36'h0_0010_0000;
    localparam logic [35:0] T1  = 36'h0_0020_0000;
    localparam logic [35:0] T2  = 36'h0_0030_0000;
    localparam logic [35:0] T3  = 36'h8_0000_0400;

    function automatic logic [31:0] mem_get(logic [35:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic logic [31:0] mk_ptd(logic [35:0] a);
        return {a[35:8], 4'h1};
    endfunction

    function automatic logic [35:0] ctx_base(logic [31:0] p);
        return {p[31:4], 8'h00};
    endfunction

    // Memory model: one-cycle read latency, optional ready stalls, write log.
    always @(posedge clk) begin
        rd_rvalid <= 1'b0;
        if (rd_valid && rd_ready) begin
            rd_rvalid <= 1'b1;
            rd_rdata  <= mem_get(rd_addr);
            if (rd_n < 8) rd_log[rd_n] = rd_addr;
            rd_n = rd_n + 1;
        end
        if (wr_valid && wr_ready) begin
            mem[wr_addr] = wr_data;
            wr_last_addr = wr_addr;
            wr_last_data = wr_data;
            wr_n = wr_n + 1;
        end
        if (done) done_n = done_n + 1;
        rd_ready <= stall ? ~rd_ready : 1'b1;
        wr_ready <= stall ? ~wr_ready : 1'b1;
    end

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_walk(logic [31:0] va, logic wr, logic [31:0] cptr, logic [7:0] cx);
        rd_n = 0; wr_n = 0; done_n = 0;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr;
        ctx_table_ptr = cptr; ctx_num = cx;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 300; i++) begin
            if (done) break;
            @(negedge clk);
        end
        chk("R10", "done seen", done, 1'b1);
    endtask

    task automatic after_done();
        @(negedge clk);
        chk("R10", "done one cycle", done, 1'b0);
        chk("R10", "done count", done_n, 1);
    endtask

    task automatic addr_chain(logic [31:0] va, logic [7:0] cx, logic [31:0] cptr,
                              output logic [35:0] a0, output logic [35:0] a1,
                              output logic [35:0] a2, output logic [35:0] a3);
        a0 = ctx_base(cptr) + 36'(cx) * 4;
        a1 = T1 + 36'(va[31:24]) * 4;
        a2 = T2 + 36'(va[23:18]) * 4;
        a3 = T3 + 36'(va[17:12]) * 4;
    endtask

    // Full three-level chain ending in the given level-3 descriptor.
    task automatic build3(logic [31:0] va, logic [7:0] cx, logic [31:0] l3);
        logic [35:0] a0, a1, a2, a3;
        mem.delete();
        addr_chain(va, cx, CTP, a0, a1, a2, a3);
        mem[a0] = mk_ptd(T1);
        mem[a1] = mk_ptd(T2);
        mem[a2] = mk_ptd(T3);
        mem[a3] = l3;
    endtask

    task automatic t_reset();
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "rd_valid", rd_valid, 0);
        chk("R1", "wr_valid", wr_valid, 0);
    endtask

    task automatic t_full_walk();
        logic [31:0] va = 32'hABCD_E567;
        logic [35:0] a0, a1, a2, a3;
        addr_chain(va, 8'd5, CTP, a0, a1, a2, a3);
        build3(va, 8'd5, 32'h1234_56E2);
        run_walk(va, 1'b0, CTP, 8'd5);
        chk("R2", "ctx read addr", rd_log[0], a0);
        chk("R3", "l1 read addr", rd_log[1], a1);
        chk("R3", "l2 read addr", rd_log[2], a2);
        chk("R3", "l3 read addr (36-bit base)", rd_log[3], a3);
        chk("R4", "reads", rd_n, 4);
        chk("R4", "level", res_level, 3);
        chk("R4", "fault", res_fault, 0);
        chk("R4", "code", res_fault_code, 0);
        chk("R7", "entry unchanged", res_entry, 32'h1234_56E2);
        chk("R7", "no write", wr_n, 0);
        after_done();
    endtask

    task automatic t_writeback();
        logic [31:0] va = 32'h0147_B000;
        logic [35:0] a0, a1, a2, a3;
        addr_chain(va, 8'd2, CTP, a0, a1, a2, a3);
        build3(va, 8'd2, 32'h0ABC_DE82);
        run_walk(va, 1'b1, CTP, 8'd2);
        chk("R6", "store wb count", wr_n, 1);
        chk("R6", "store wb addr", wr_last_addr, a3);
        chk("R6", "store wb data", wr_last_data, 32'h0ABC_DEE2);
        chk("R6", "store entry", res_entry, 32'h0ABC_DEE2);
        after_done();
        build3(va, 8'd2, 32'h0ABC_DE82);
        run_walk(va, 1'b0, CTP, 8'd2);
        chk("R6", "load wb data ref only", wr_last_data, 32'h0ABC_DEA2);
        chk("R6", "load wb count", wr_n, 1);
        after_done();
        build3(va, 8'd2, 32'h0ABC_DEA2);
        run_walk(va, 1'b0, CTP, 8'd2);
        chk("R7", "load ref set no wb", wr_n, 0);
        chk("R7", "load entry", res_entry, 32'h0ABC_DEA2);
        after_done();
        build3(va, 8'd2, 32'h0ABC_DEA2);
        run_walk(va, 1'b1, CTP, 8'd2);
        chk("R6", "store mod clear wb", wr_last_data, 32'h0ABC_DEE2);
        after_done();
    endtask

    task automatic t_early_leaf();
        logic [31:0] va = 32'hFE30_4000;
        logic [31:0] cp = 32'h0005_0010;
        logic [35:0] a0, a1, a2, a3;
        addr_chain(va, 8'hFF, cp, a0, a1, a2, a3);
        mem.delete();
        mem[a0] = mk_ptd(T1);
        mem[a1] = 32'h0FF0_00E2;
        run_walk(va, 1'b0, cp, 8'hFF);
        chk("R2", "ctx addr max ctx", rd_log[0], a0);
        chk("R4", "l1 leaf level", res_level, 1);
        chk("R4", "l1 leaf reads", rd_n, 2);
        after_done();
        mem[a1] = mk_ptd(T2);
        mem[a2] = 32'h0EE0_00E2;
        run_walk(va, 1'b0, cp, 8'hFF);
        chk("R4", "l2 leaf level", res_level, 2);
        chk("R4", "l2 leaf reads", rd_n, 3);
        chk("R4", "l2 leaf entry", res_entry, 32'h0EE0_00E2);
        after_done();
        mem[a0] = 32'h0000_00E2;
        run_walk(va, 1'b0, cp, 8'hFF);
        chk("R4", "ctx leaf level", res_level, 0);
        chk("R4", "ctx leaf reads", rd_n, 1);
        chk("R4", "ctx leaf fault", res_fault, 0);
        after_done();
    endtask

    task automatic t_faults();
        logic [31:0] va = 32'h5A5A_5000;
        logic [35:0] a0, a1, a2, a3;
        addr_chain(va, 8'd9, CTP, a0, a1, a2, a3);
        build3(va, 8'd9, 32'h0);
        mem[a2] = 32'h0000_0000;
        run_walk(va, 1'b1, CTP, 8'd9);
        chk("R5", "invalid fault", res_fault, 1);
        chk("R5", "invalid code", res_fault_code, 1);
        chk("R5", "invalid level", res_level, 2);
        chk("R5", "fault vaddr", res_fault_vaddr, va);
        chk("R5", "invalid no write", wr_n, 0);
        after_done();
        mem[a1] = 32'h1234_0003;
        run_walk(va, 1'b0, CTP, 8'd9);
        chk("R5", "reserved code", res_fault_code, 2);
        chk("R5", "reserved level", res_level, 1);
        after_done();
        build3(va, 8'd9, mk_ptd(T1));
        run_walk(va, 1'b1, CTP, 8'd9);
        chk("R5", "depth code", res_fault_code, 3);
        chk("R5", "depth level", res_level, 3);
        chk("R5", "depth reads", rd_n, 4);
        chk("R5", "depth no write", wr_n, 0);
        after_done();
    endtask

    task automatic t_busy_refuse();
        logic [31:0] va  = 32'h3C21_7000;
        logic [31:0] va2 = 32'hC3DE_8000;
        logic [35:0] a0, a1, a2, a3;
        addr_chain(va, 8'd1, CTP, a0, a1, a2, a3);
        build3(va, 8'd1, 32'h0000_1182);
        stall = 1'b1;
        rd_n = 0; wr_n = 0; done_n = 0;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = 1'b0;
        ctx_table_ptr = CTP; ctx_num = 8'd1;
        @(negedge clk);
        req_vaddr = va2; req_write = 1'b1; ctx_num = 8'd7;
        chk("R8", "busy mid walk", busy, 1);
        for (int i = 0; i < 300; i++) begin
            if (done) break;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk("R10", "done seen stalled", done, 1);
        chk("R8", "ctx addr kept", rd_log[0], a0);
        chk("R8", "l3 addr kept", rd_log[3], a3);
        chk("R8", "vaddr kept", res_fault_vaddr, va);
        chk("R6", "stalled wb load data", wr_last_data, 32'h0000_11A2);
        after_done();
        chk("R8", "idle after", busy, 0);
        stall = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_full_walk();
        t_writeback();
        t_early_leaf();
        t_faults();
        t_busy_refuse();
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end
endmodule